// File: doc/BRIEF.md
# Transmit Descriptor Process Controller

This block is the control state machine of a transmit DMA engine. It walks a list of transmit descriptors, one frame per descriptor. It requests the first descriptor word and checks whether the engine owns it. It then follows the transmit FIFO through the frame and writes the descriptor's first word back with the outcome. Data movement, PHY signalling and collision handling are handled elsewhere.

The process is always in one of three conditions: Stopped, Running or Suspended. Running is split into fetch, frame-wait and write-back phases. Two error outcomes are treated differently. A FIFO underflow writes its error bit into the descriptor and parks the engine in Suspended, from which a poll demand resumes it. A jabber timeout writes a different error bit and drops the engine to Stopped. A descriptor bus error is fatal: the engine makes no further bus accesses until reset. Seven sticky flags report events to software, and each is cleared by writing a one to it.

Top module: `txdma_ctrl`

## Requirements
- R1: After reset, state_o is 000, sts_o is all zero, and desc_req_o and wb_vld_o are low.
- R2: With run_i high in Stopped (000), the block enters fetch (001) and holds desc_req_o high until a response arrives. An owned word with no error moves it to frame-wait (010).
- R3: A response whose bit 31 is 0 (host-owned) puts the block in Suspended (110) and sets sts_o[2]. While suspended, FIFO handshakes are ignored. poll_i returns the block to fetch, and run_i low moves it to Stopped.
- R4: The written-back word (wb_vld_o high for one cycle, state 011) equals the fetched word with bit 31 cleared. Bit 14 is set only for a jabber abort and bit 1 only for an underflow. All other bits are kept.
- R5: underflow_i during frame-wait leads to a write-back with bit 1 set, then to Suspended with sts_o[4] set.
- R6: When tx_active_i has been high for JAB_LIMIT consecutive cycles during frame-wait, the block writes back with bit 14 set. It then enters Stopped and sets sts_o[3] and sts_o[1].
- R7: The jabber count restarts whenever tx_active_i drops. Two runs of JAB_LIMIT-1 active cycles separated by one idle cycle cause no abort.
- R8: frame_loaded_i during frame-wait sets sts_o[5] while the frame is still in flight.
- R9: frame_sent_i during frame-wait leads to a write-back and sets sts_o[0]. The block then fetches again if run_i is high. Otherwise it enters Stopped and sets sts_o[1].
- R10: An error response to a fetch sets sts_o[6] and sts_o[1] and enters Stopped. After that, desc_req_o and wb_vld_o stay low until reset, whatever run_i and poll_i do.
- R11: Each sts_o bit stays set until a 1 is written to the same bit of sts_clr_i. A set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Start (1) / stop (0) request |
| poll_i | input | 1 | Transmit poll demand pulse |
| desc_req_o | output | 1 | Descriptor first-word read request |
| desc_rsp_vld_i | input | 1 | Descriptor response valid |
| desc_rsp_err_i | input | 1 | Response carries a bus error |
| desc_rsp_word_i | input | DW | Descriptor first word, bit 31 = engine owns |
| wb_vld_o | output | 1 | Status write-back strobe |
| wb_word_o | output | DW | Status word to write back |
| frame_loaded_i | input | 1 | Whole frame is in the transmit FIFO |
| frame_sent_i | input | 1 | Frame transmission finished |
| underflow_i | input | 1 | Transmit FIFO underflow |
| tx_active_i | input | 1 | Transmitter active, feeds the jabber timer |
| sts_clr_i | input | 7 | Write-1-to-clear for sts_o |
| sts_o | output | 7 | Sticky flags: 0 done, 1 stopped, 2 buffer unavailable, 3 jabber, 4 underflow, 5 early transmit, 6 fatal bus error |
| state_o | output | 3 | 000 stopped, 001 fetch, 010 frame-wait, 011 write-back, 110 suspended |

## Verification
The bench sets JAB_LIMIT to 16, down from the default 2048. At that value the jabber abort and the restart-on-idle boundary (15 active, 1 idle, 15 active) each take a few dozen cycles. DW stays at 32 with the default bit positions, so the write-back words are checked at full width against the ownership and both error bits.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  typedef enum logic [2:0] {
    ST_STOP  = 3'b000,
    ST_FETCH = 3'b001,
    ST_XFER  = 3'b010,
    ST_WB    = 3'b011,
    ST_SUSP  = 3'b110
  } tx_state_e;

  typedef enum logic [1:0] {
    OUT_OK  = 2'd0,
    OUT_UNF = 2'd1,
    OUT_JAB = 2'd2
  } tx_outcome_e;

  localparam int F_DONE  = 0;
  localparam int F_STOP  = 1;
  localparam int F_BUFU  = 2;
  localparam int F_JAB   = 3;
  localparam int F_UNF   = 4;
  localparam int F_EARLY = 5;
  localparam int F_FATAL = 6;
  localparam int NFLAG   = 7;
endpackage

// File: rtl/txdma_jabber.sv
module txdma_jabber #(
  parameter int LIMIT = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic active_i,
  output logic expired_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  // consecutive active cycles, saturating at the limit
  always_ff @(posedge clk) begin
    if (rst || !active_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LIM) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = (cnt_q == LIM);
endmodule

// File: rtl/txdma_flags.sv
module txdma_flags #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q;

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) flags_q[g] <= 1'b0;
      else     flags_q[g] <= set_i[g] | (flags_q[g] & ~clr_i[g]);
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/txdma_fsm.sv
module txdma_fsm
  import txdma_pkg::*;
#(
  parameter int DW      = 32,
  parameter int OWN_BIT = 31,
  parameter int JAB_BIT = 14,
  parameter int UNF_BIT = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             poll_i,
  input  logic             rsp_vld_i,
  input  logic             rsp_err_i,
  input  logic [DW-1:0]    rsp_word_i,
  input  logic             loaded_i,
  input  logic             sent_i,
  input  logic             unf_i,
  input  logic             jab_i,
  output logic             req_o,
  output logic             wb_vld_o,
  output logic [DW-1:0]    wb_word_o,
  output logic [NFLAG-1:0] set_o,
  output logic [2:0]       state_o
);
  tx_state_e   state_q, state_d;
  tx_outcome_e out_q, out_d;
  logic [DW-1:0] word_q, wb_q, wb_d;
  logic          dead_q;
  logic          take_word;

  always_comb begin
    state_d   = state_q;
    out_d     = out_q;
    set_o     = '0;
    take_word = 1'b0;
    wb_d      = wb_q;
    case (state_q)
      ST_STOP: begin
        if (run_i && !dead_q) state_d = ST_FETCH;
      end
      ST_FETCH: begin
        if (rsp_vld_i) begin
          if (rsp_err_i) begin
            state_d        = ST_STOP;
            set_o[F_FATAL] = 1'b1;
            set_o[F_STOP]  = 1'b1;
          end else if (!rsp_word_i[OWN_BIT]) begin
            state_d       = ST_SUSP;
            set_o[F_BUFU] = 1'b1;
          end else begin
            state_d   = ST_XFER;
            take_word = 1'b1;
          end
        end
      end
      ST_XFER: begin
        if (loaded_i) set_o[F_EARLY] = 1'b1;
        if (jab_i || unf_i || sent_i) begin
          state_d = ST_WB;
          out_d   = jab_i ? OUT_JAB : (unf_i ? OUT_UNF : OUT_OK);
          wb_d          = word_q;
          wb_d[OWN_BIT] = 1'b0;
          wb_d[JAB_BIT] = jab_i;
          wb_d[UNF_BIT] = unf_i && !jab_i;
        end
      end
      ST_WB: begin
        case (out_q)
          OUT_JAB: begin
            state_d       = ST_STOP;
            set_o[F_JAB]  = 1'b1;
            set_o[F_STOP] = 1'b1;
          end
          OUT_UNF: begin
            state_d      = ST_SUSP;
            set_o[F_UNF] = 1'b1;
          end
          default: begin
            set_o[F_DONE] = 1'b1;
            if (run_i) begin
              state_d = ST_FETCH;
            end else begin
              state_d       = ST_STOP;
              set_o[F_STOP] = 1'b1;
            end
          end
        endcase
      end
      ST_SUSP: begin
        if (!run_i) begin
          state_d       = ST_STOP;
          set_o[F_STOP] = 1'b1;
        end else if (poll_i) begin
          state_d = ST_FETCH;
        end
      end
      default: state_d = ST_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_STOP;
      out_q   <= OUT_OK;
      word_q  <= '0;
      wb_q    <= '0;
      dead_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      out_q   <= out_d;
      wb_q    <= wb_d;
      if (take_word) word_q <= rsp_word_i;
      if (state_q == ST_FETCH && rsp_vld_i && rsp_err_i) dead_q <= 1'b1;
    end
  end

  assign req_o     = (state_q == ST_FETCH);
  assign wb_vld_o  = (state_q == ST_WB);
  assign wb_word_o = wb_q;
  assign state_o   = state_q;
endmodule

// File: rtl/txdma_ctrl.sv
module txdma_ctrl
  import txdma_pkg::*;
#(
  parameter int DW        = 32,
  parameter int JAB_LIMIT = 2048,
  parameter int OWN_BIT   = 31,
  parameter int JAB_BIT   = 14,
  parameter int UNF_BIT   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             poll_i,
  output logic             desc_req_o,
  input  logic             desc_rsp_vld_i,
  input  logic             desc_rsp_err_i,
  input  logic [DW-1:0]    desc_rsp_word_i,
  output logic             wb_vld_o,
  output logic [DW-1:0]    wb_word_o,
  input  logic             frame_loaded_i,
  input  logic             frame_sent_i,
  input  logic             underflow_i,
  input  logic             tx_active_i,
  input  logic [NFLAG-1:0] sts_clr_i,
  output logic [NFLAG-1:0] sts_o,
  output logic [2:0]       state_o
);
  logic             jab_exp;
  logic [NFLAG-1:0] flag_set;

  txdma_jabber #(.LIMIT(JAB_LIMIT)) u_jab (
    .clk       (clk),
    .rst       (rst),
    .active_i  (tx_active_i),
    .expired_o (jab_exp)
  );

  txdma_fsm #(
    .DW(DW), .OWN_BIT(OWN_BIT), .JAB_BIT(JAB_BIT), .UNF_BIT(UNF_BIT)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .run_i      (run_i),
    .poll_i     (poll_i),
    .rsp_vld_i  (desc_rsp_vld_i),
    .rsp_err_i  (desc_rsp_err_i),
    .rsp_word_i (desc_rsp_word_i),
    .loaded_i   (frame_loaded_i),
    .sent_i     (frame_sent_i),
    .unf_i      (underflow_i),
    .jab_i      (jab_exp),
    .req_o      (desc_req_o),
    .wb_vld_o   (wb_vld_o),
    .wb_word_o  (wb_word_o),
    .set_o      (flag_set),
    .state_o    (state_o)
  );

  txdma_flags #(.N(NFLAG)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_i   (flag_set),
    .clr_i   (sts_clr_i),
    .flags_o (sts_o)
  );
endmodule

// File: rtl/txdma_ctrl_chk.sv
module txdma_ctrl_chk #(
  parameter int NF = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          desc_req_o,
  input logic          desc_rsp_vld_i,
  input logic          desc_rsp_err_i,
  input logic          rsp_own,
  input logic          wb_vld_o,
  input logic          wb_own,
  input logic          wb_jab,
  input logic          wb_unf,
  input logic [NF-1:0] sts_clr_i,
  input logic [NF-1:0] sts_o,
  input logic [2:0]    state_o
);
  a_r2_req_in_fetch: assert property (@(posedge clk) disable iff (rst)
    desc_req_o |-> (state_o == 3'b001));

  a_r3_host_owned_suspends: assert property (@(posedge clk) disable iff (rst)
    (desc_req_o && desc_rsp_vld_i && !desc_rsp_err_i && !rsp_own)
      |=> (state_o == 3'b110 && sts_o[2]));

  a_r4_own_cleared: assert property (@(posedge clk) disable iff (rst)
    wb_vld_o |-> !wb_own);

  a_r5_underflow_suspends: assert property (@(posedge clk) disable iff (rst)
    (wb_vld_o && wb_unf) |=> (state_o == 3'b110 && sts_o[4]));

  a_r6_jabber_stops: assert property (@(posedge clk) disable iff (rst)
    (wb_vld_o && wb_jab) |=> (state_o == 3'b000 && sts_o[3] && sts_o[1]));

  a_r10_fatal_stops: assert property (@(posedge clk) disable iff (rst)
    (desc_req_o && desc_rsp_vld_i && desc_rsp_err_i)
      |=> (state_o == 3'b000 && sts_o[6] && !desc_req_o));

  a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> ((($past(sts_o) & ~sts_o) & ~$past(sts_clr_i)) == '0));
endmodule

bind txdma_ctrl txdma_ctrl_chk #(.NF(txdma_pkg::NFLAG)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .desc_req_o     (desc_req_o),
  .desc_rsp_vld_i (desc_rsp_vld_i),
  .desc_rsp_err_i (desc_rsp_err_i),
  .rsp_own        (desc_rsp_word_i[OWN_BIT]),
  .wb_vld_o       (wb_vld_o),
  .wb_own         (wb_word_o[OWN_BIT]),
  .wb_jab         (wb_word_o[JAB_BIT]),
  .wb_unf         (wb_word_o[UNF_BIT]),
  .sts_clr_i      (sts_clr_i),
  .sts_o          (sts_o),
  .state_o        (state_o)
);

// File: tb/txdma_ctrl_tb.sv
module txdma_ctrl_tb;
  localparam int LIM = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 0, poll = 0, vld = 0, err = 0;
  logic [31:0] word = '0;
  logic        loaded = 0, sent = 0, unf = 0, act = 0;
  logic [6:0]  clr = '0;
  logic        req, wbv;
  logic [31:0] wbw;
  logic [6:0]  sts;
  logic [2:0]  st;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  txdma_ctrl #(.DW(32), .JAB_LIMIT(LIM)) u_dut (
    .clk(clk), .rst(rst), .run_i(run), .poll_i(poll),
    .desc_req_o(req), .desc_rsp_vld_i(vld), .desc_rsp_err_i(err),
    .desc_rsp_word_i(word), .wb_vld_o(wbv), .wb_word_o(wbw),
    .frame_loaded_i(loaded), .frame_sent_i(sent), .underflow_i(unf),
    .tx_active_i(act), .sts_clr_i(clr), .sts_o(sts), .state_o(st)
  );

  // stimulus {run,poll,vld,own,err,loaded,sent,unf}, expect {state,req,wb,sts}
  localparam logic [19:0] VEC [12] = '{
    {8'b1000_0000, 3'b001, 1'b1, 1'b0, 7'h00},
    {8'b1011_0000, 3'b010, 1'b0, 1'b0, 7'h00},
    {8'b1000_0100, 3'b010, 1'b0, 1'b0, 7'h20},
    {8'b1000_0010, 3'b011, 1'b0, 1'b1, 7'h20},
    {8'b1000_0000, 3'b001, 1'b1, 1'b0, 7'h21},
    {8'b1010_0000, 3'b110, 1'b0, 1'b0, 7'h25},
    {8'b1000_0010, 3'b110, 1'b0, 1'b0, 7'h25},
    {8'b1100_0000, 3'b001, 1'b1, 1'b0, 7'h25},
    {8'b1011_0000, 3'b010, 1'b0, 1'b0, 7'h25},
    {8'b1000_0001, 3'b011, 1'b0, 1'b1, 7'h25},
    {8'b1000_0000, 3'b110, 1'b0, 1'b0, 7'h35},
    {8'b0000_0000, 3'b000, 1'b0, 1'b0, 7'h37}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req_s, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req_s, got, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1; run = 0; poll = 0; vld = 0; err = 0; word = '0;
    loaded = 0; sent = 0; unf = 0; act = 0; clr = '0;
    step(); step();
    rst = 0;
  endtask

  task automatic fetch_frame(input logic [31:0] w);
    run = 1;
    step();
    vld = 1; word = w;
    step();
    vld = 0; word = '0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 state", {29'd0, st}, 32'd0);
    chk("R1 sts", {25'd0, sts}, 32'd0);
    chk("R1 req/wb", {30'd0, req, wbv}, 32'd0);

    // table walk: R2 R3 R5 R8 R9 flow
    for (int i = 0; i < 12; i++) begin
      {run, poll, vld, word[31], err, loaded, sent, unf} = VEC[i][19:12];
      step();
      chk($sformatf("R2/R3/R5/R8/R9 row %0d", i),
          {20'd0, st, req, wbv, sts}, {20'd0, VEC[i][11:0]});
    end
    {run, poll, vld, word, err, loaded, sent, unf} = '0;

    // R11 clear all
    clr = 7'h7F; step(); clr = '0;
    chk("R11 clear", {25'd0, sts}, 32'd0);

    // R4 write-back word, then R9 stop after completion
    do_reset();
    fetch_frame(32'h8000_4003);
    sent = 1; step(); sent = 0;
    chk("R4 wb strobe", {31'd0, wbv}, 32'd1);
    chk("R4 wb word", wbw, 32'h0000_0001);
    run = 0; step();
    chk("R9 stop state", {29'd0, st}, 32'd0);
    chk("R9 stop sts", {25'd0, sts}, 32'h03);

    // R5 underflow word
    do_reset();
    fetch_frame(32'h8000_00F0);
    unf = 1; step(); unf = 0;
    chk("R5 wb word", wbw, 32'h0000_00F2);

    // R6 jabber abort
    do_reset();
    fetch_frame(32'h8123_0000);
    act = 1;
    repeat (LIM) step();
    chk("R6 before abort", {29'd0, st}, 32'd2);
    step();
    chk("R6 wb word", wbw, 32'h0123_4000);
    act = 0; step();
    chk("R6 state", {29'd0, st}, 32'd0);
    chk("R6 sts", {25'd0, sts}, 32'h0A);

    // R7 timer restarts on idle
    do_reset();
    fetch_frame(32'h8000_0000);
    act = 1; repeat (LIM - 1) step();
    act = 0; step();
    act = 1; repeat (LIM - 1) step();
    chk("R7 no abort", {29'd0, st}, 32'd2);
    act = 0; sent = 1; step(); sent = 0;
    chk("R7 clean wb", wbw, 32'h0);
    step();
    chk("R7 refetch", {25'd0, sts}, 32'h01);

    // R10 fatal bus error
    do_reset();
    run = 1; step();
    vld = 1; err = 1; step(); vld = 0; err = 0;
    chk("R10 state", {29'd0, st}, 32'd0);
    chk("R10 sts", {25'd0, sts}, 32'h42);
    poll = 1;
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R10 no access", {30'd0, req, wbv}, 32'd0);
    end
    poll = 0;

    // R11 set wins over clear
    do_reset();
    fetch_frame(32'h8000_0000);
    loaded = 1; clr = 7'h7F; step(); loaded = 0; clr = '0;
    chk("R11 set wins", {25'd0, sts}, 32'h20);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule